// File: doc/BRIEF.md
# Code-Segment Fetch Address Unit

This block holds the state that turns a segmented code pointer into a flat fetch address for an instruction sequencer. It has a visible 16-bit code selector, a hidden cached segment base and segment limit, and a 32-bit instruction offset. The fetch address is always the hidden base plus the offset. No logic forces any address bit.

A power-on reset puts a hidden base into the segment register that the selector cannot produce. With selector 0xF000, base 0xFFFF0000 and offset 0xFFF0, the first fetch comes from 0xFFFFFFF0, near the top of the 32-bit space. Near jumps change only the offset, so that high base stays in force. The first far load, which stands for a far jump or an interrupt entry, rebuilds the base from the selector shifted left by four. From then on, fetches fall inside the low megabyte.

Top module: `cs_fetch_unit`

## Requirements
- R1: On a clock edge with `rst` high, the selector becomes 0xF000, the base 0xFFFF0000, the limit 0x0000FFFF and the offset 0xFFF0. The fetch address becomes 0xFFFFFFF0 and `ip_fault` becomes 0.
- R2: `fetch_addr` always equals `cs_base` plus the current offset, taken modulo 2^32.
- R3: A near jump loads `near_ofs` into the offset. It leaves selector, base and limit unchanged.
- R4: A far load sets the selector to `far_sel`, the base to `far_sel` shifted left by 4 and zero-extended, the limit to 0x0000FFFF and the offset to `far_ofs`. All of this happens on one edge.
- R5: After any far load, bits 31..20 of `cs_base` are zero.
- R6: An advance adds `adv_bytes` (1 to 15) to bits 15..0 of the offset, wrapping modulo 2^16. Bits 31..16 of the offset stay unchanged.
- R7: `ip_fault` is 1 exactly when the offset is greater than `cs_limit`. `fetch_addr` is still driven as base plus offset while the fault is set.
- R8: When several requests are present on one edge, only the highest-priority one takes effect. The order is `rst`, then `far_en`, then `near_en`, then `adv_en`.
- R9: All outputs show the effect of a request on the same clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the power-on vector |
| adv_en | input | 1 | Sequential advance request |
| adv_bytes | input | 4 | Byte count for an advance |
| near_en | input | 1 | Near jump request |
| near_ofs | input | 32 | New offset for a near jump |
| far_en | input | 1 | Far code-segment load request |
| far_sel | input | 16 | New selector for a far load |
| far_ofs | input | 32 | New offset for a far load |
| fetch_addr | output | 32 | Registered linear fetch address |
| cs_sel | output | 16 | Visible code selector |
| cs_base | output | 32 | Hidden segment base |
| cs_limit | output | 32 | Hidden segment limit |
| ip_fault | output | 1 | Offset lies above the segment limit |

## Verification
The bench builds the unit with its default widths: a 16-bit selector, a shift of four, a 32-bit address and a 4-bit byte count. With these widths it can apply every advance count from 1 to 15 in turn. The accumulated sum carries the offset through its 16-bit wrap starting from the reset value 0xFFF0. A sweep of 64 selectors spread across the whole 16-bit range checks the shifted base and the low-megabyte bound. Directed priority cases and an offset above the limit cover fault reporting, 32-bit address wrap and the ordering of requests that arrive together.

// File: rtl/cs_fetch_pkg.sv
package cs_fetch_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_STEP  = 3'd1,
    OP_NEAR  = 3'd2,
    OP_FAR   = 3'd3,
    OP_RESET = 3'd4
  } cs_op_e;
endpackage

// File: rtl/cs_op_arbiter.sv
module cs_op_arbiter
  import cs_fetch_pkg::*;
(
  input  logic   rst,
  input  logic   far_en,
  input  logic   near_en,
  input  logic   adv_en,
  output cs_op_e op
);
  always_comb begin
    if (rst)          op = OP_RESET;
    else if (far_en)  op = OP_FAR;
    else if (near_en) op = OP_NEAR;
    else if (adv_en)  op = OP_STEP;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/cs_segment_regs.sv
module cs_segment_regs
  import cs_fetch_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SEL_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter logic [SEL_W-1:0]  RST_SEL   = 16'hF000,
  parameter logic [ADDR_W-1:0] RST_BASE  = 32'hFFFF0000,
  parameter logic [ADDR_W-1:0] RST_LIMIT = 32'h0000FFFF,
  parameter logic [ADDR_W-1:0] FAR_LIMIT = 32'h0000FFFF
) (
  input  logic              clk,
  input  cs_op_e            op,
  input  logic [SEL_W-1:0]  far_sel,
  output logic [SEL_W-1:0]  sel_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] limit_q,
  output logic [ADDR_W-1:0] base_nxt,
  output logic [ADDR_W-1:0] limit_nxt
);
  localparam int PAD_W = ADDR_W - SEL_W - SEG_SHIFT;

  logic [SEL_W-1:0]  sel_nxt;
  logic [ADDR_W-1:0] shifted_base;

  // Real-mode base: selector times sixteen, upper bits cleared
  assign shifted_base = {{PAD_W{1'b0}}, far_sel, {SEG_SHIFT{1'b0}}};

  always_comb begin
    sel_nxt   = sel_q;
    base_nxt  = base_q;
    limit_nxt = limit_q;
    case (op)
      OP_RESET: begin
        sel_nxt   = RST_SEL;
        base_nxt  = RST_BASE;
        limit_nxt = RST_LIMIT;
      end
      OP_FAR: begin
        sel_nxt   = far_sel;
        base_nxt  = shifted_base;
        limit_nxt = FAR_LIMIT;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    sel_q   <= sel_nxt;
    base_q  <= base_nxt;
    limit_q <= limit_nxt;
  end
endmodule

// File: rtl/cs_ip_reg.sv
module cs_ip_reg
  import cs_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP_W = 4,
  parameter int WRAP_W = 16,
  parameter logic [ADDR_W-1:0] RST_IP = 32'h0000FFF0
) (
  input  logic              clk,
  input  cs_op_e            op,
  input  logic [STEP_W-1:0] adv_bytes,
  input  logic [ADDR_W-1:0] near_ofs,
  input  logic [ADDR_W-1:0] far_ofs,
  output logic [ADDR_W-1:0] ip_q,
  output logic [ADDR_W-1:0] ip_nxt
);
  logic [WRAP_W-1:0] low_sum;

  assign low_sum = ip_q[WRAP_W-1:0] + WRAP_W'(adv_bytes);

  always_comb begin
    case (op)
      OP_RESET: ip_nxt = RST_IP;
      OP_FAR:   ip_nxt = far_ofs;
      OP_NEAR:  ip_nxt = near_ofs;
      OP_STEP:  ip_nxt = {ip_q[ADDR_W-1:WRAP_W], low_sum};
      default:  ip_nxt = ip_q;
    endcase
  end

  always_ff @(posedge clk) begin
    ip_q <= ip_nxt;
  end
endmodule

// File: rtl/cs_fetch_gen.sv
module cs_fetch_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] base_nxt,
  input  logic [ADDR_W-1:0] limit_nxt,
  input  logic [ADDR_W-1:0] ip_nxt,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              ip_fault
);
  always_ff @(posedge clk) begin
    fetch_addr <= base_nxt + ip_nxt;
    ip_fault   <= (ip_nxt > limit_nxt);
  end
endmodule

// File: rtl/cs_fetch_unit.sv
module cs_fetch_unit
  import cs_fetch_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SEL_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int STEP_W    = 4,
  parameter int WRAP_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_en,
  input  logic [STEP_W-1:0] adv_bytes,
  input  logic              near_en,
  input  logic [ADDR_W-1:0] near_ofs,
  input  logic              far_en,
  input  logic [SEL_W-1:0]  far_sel,
  input  logic [ADDR_W-1:0] far_ofs,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [SEL_W-1:0]  cs_sel,
  output logic [ADDR_W-1:0] cs_base,
  output logic [ADDR_W-1:0] cs_limit,
  output logic              ip_fault
);
  localparam int REAL_TOP = SEL_W + SEG_SHIFT;

  cs_op_e            op;
  logic [ADDR_W-1:0] base_nxt, limit_nxt, ip_nxt, ip_q;

  cs_op_arbiter u_arb (
    .rst(rst), .far_en(far_en), .near_en(near_en), .adv_en(adv_en), .op(op)
  );

  cs_segment_regs #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .SEG_SHIFT(SEG_SHIFT)
  ) u_seg (
    .clk(clk), .op(op), .far_sel(far_sel),
    .sel_q(cs_sel), .base_q(cs_base), .limit_q(cs_limit),
    .base_nxt(base_nxt), .limit_nxt(limit_nxt)
  );

  cs_ip_reg #(
    .ADDR_W(ADDR_W), .STEP_W(STEP_W), .WRAP_W(WRAP_W)
  ) u_ip (
    .clk(clk), .op(op), .adv_bytes(adv_bytes),
    .near_ofs(near_ofs), .far_ofs(far_ofs),
    .ip_q(ip_q), .ip_nxt(ip_nxt)
  );

  cs_fetch_gen #(.ADDR_W(ADDR_W)) u_gen (
    .clk(clk), .base_nxt(base_nxt), .limit_nxt(limit_nxt), .ip_nxt(ip_nxt),
    .fetch_addr(fetch_addr), .ip_fault(ip_fault)
  );

  // Reset vector lands in every visible register
  assert_reset_vector_R1: assert property (@(posedge clk)
    $past(rst) |-> (cs_sel == 16'hF000 && cs_base == 32'hFFFF0000 &&
                    cs_limit == 32'h0000FFFF && fetch_addr == 32'hFFFFFFF0 && !ip_fault));

  // Address generator agrees with the separately held base and offset
  assert_fetch_sum_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> fetch_addr == cs_base + ip_q);

  assert_near_keeps_seg_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(far_en) && $past(near_en)) |->
      ($stable(cs_base) && $stable(cs_sel) && $stable(cs_limit)));

  assert_far_base_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(far_en)) |->
      (cs_base == (ADDR_W'($past(far_sel)) << SEG_SHIFT) && cs_sel == $past(far_sel)));

  assert_low_meg_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(far_en)) |-> ((cs_base >> REAL_TOP) == '0));

  assert_fault_flag_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ip_fault == (ip_q > cs_limit)));
endmodule

// File: tb/cs_fetch_unit_test.sv
module cs_fetch_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_en = 1'b0;
  logic [3:0]  adv_bytes = '0;
  logic        near_en = 1'b0;
  logic [31:0] near_ofs = '0;
  logic        far_en = 1'b0;
  logic [15:0] far_sel = '0;
  logic [31:0] far_ofs = '0;
  logic [31:0] fetch_addr, cs_base, cs_limit;
  logic [15:0] cs_sel;
  logic        ip_fault;

  int n_run = 0;
  int n_fail = 0;

  logic [15:0] m_sel;
  logic [31:0] m_base, m_limit, m_ip;

  always #4 clk = ~clk;

  cs_fetch_unit uut (
    .clk(clk), .rst(rst), .adv_en(adv_en), .adv_bytes(adv_bytes),
    .near_en(near_en), .near_ofs(near_ofs), .far_en(far_en),
    .far_sel(far_sel), .far_ofs(far_ofs), .fetch_addr(fetch_addr),
    .cs_sel(cs_sel), .cs_base(cs_base), .cs_limit(cs_limit), .ip_fault(ip_fault)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_model(input string req);
    chk(req, "sel",   {16'h0, cs_sel}, {16'h0, m_sel});
    chk(req, "base",  cs_base, m_base);
    chk(req, "limit", cs_limit, m_limit);
    chk(req, "fetch", fetch_addr, m_base + m_ip);
    chk(req, "fault", {31'h0, ip_fault}, {31'h0, (m_ip > m_limit)});
  endtask

  // Apply one set of requests for one edge, update the model, check (R8, R9)
  task automatic cycle(input logic r, input logic f, input logic n, input logic a,
                       input string req);
    rst = r; far_en = f; near_en = n; adv_en = a;
    @(posedge clk);
    #2;
    if (r) begin
      m_sel = 16'hF000; m_base = 32'hFFFF0000; m_limit = 32'h0000FFFF; m_ip = 32'h0000FFF0;
    end else if (f) begin
      m_sel = far_sel; m_base = {12'h0, far_sel, 4'h0}; m_limit = 32'h0000FFFF; m_ip = far_ofs;
    end else if (n) begin
      m_ip = near_ofs;
    end else if (a) begin
      m_ip = {m_ip[31:16], m_ip[15:0] + {12'h0, adv_bytes}};
    end
    check_model(req);
    rst = 1'b0; far_en = 1'b0; near_en = 1'b0; adv_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_sel = '0; m_base = '0; m_limit = '0; m_ip = '0;
    cycle(1'b1, 1'b0, 1'b0, 1'b0, "R1");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, "R1");
    chk("R1", "first fetch", fetch_addr, 32'hFFFFFFF0);

    // R6 sweep every count; the running sum wraps the low 16 bits
    for (int c = 1; c < 16; c++) begin
      adv_bytes = 4'(c);
      cycle(1'b0, 1'b0, 1'b0, 1'b1, "R6");
    end
    chk("R6", "wrapped offset fetch", fetch_addr, 32'hFFFF0068);

    // R3 near jump keeps the high reset base
    near_ofs = 32'h0000_0100;
    cycle(1'b0, 1'b0, 1'b1, 1'b0, "R3");
    chk("R3", "near fetch", fetch_addr, 32'hFFFF0100);

    // R7 offset above limit: fault, address still base+offset (R2 wrap)
    near_ofs = 32'h0001_2345;
    cycle(1'b0, 1'b0, 1'b1, 1'b0, "R7");
    chk("R7", "fault flag", {31'h0, ip_fault}, 32'h1);
    chk("R2", "wrapped fetch", fetch_addr, 32'h00002345);
    adv_bytes = 4'd1;
    cycle(1'b0, 1'b0, 1'b0, 1'b1, "R6");
    chk("R6", "upper offset kept", fetch_addr, 32'h00002346);

    // R4 far load 1234:0010
    far_sel = 16'h1234; far_ofs = 32'h0000_0010;
    cycle(1'b0, 1'b1, 1'b0, 1'b0, "R4");
    chk("R4", "far fetch", fetch_addr, 32'h00012350);
    chk("R5", "base high bits", cs_base >> 20, 32'h0);

    // R6 wrap after a far load
    far_sel = 16'h0040; far_ofs = 32'h0000_FFFE;
    cycle(1'b0, 1'b1, 1'b0, 1'b0, "R4");
    adv_bytes = 4'd3;
    cycle(1'b0, 1'b0, 1'b0, 1'b1, "R6");
    chk("R6", "low wrap", fetch_addr, 32'h00000401);

    // R4/R5 selector sweep
    for (int i = 0; i < 64; i++) begin
      far_sel = 16'(i * 16'h0421);
      far_ofs = 32'(i * 32'h0403);
      cycle(1'b0, 1'b1, 1'b0, 1'b0, "R4");
      chk("R5", "base high bits", cs_base >> 20, 32'h0);
    end
    far_sel = 16'hFFFF; far_ofs = 32'h0000_FFFF;
    cycle(1'b0, 1'b1, 1'b0, 1'b0, "R5");
    chk("R5", "top selector base", cs_base, 32'h000FFFF0);

    // R8 priority cases
    far_sel = 16'h2000; far_ofs = 32'h8; near_ofs = 32'h77; adv_bytes = 4'd5;
    cycle(1'b1, 1'b1, 1'b1, 1'b1, "R8");
    chk("R8", "reset wins", fetch_addr, 32'hFFFFFFF0);
    cycle(1'b0, 1'b1, 1'b1, 1'b1, "R8");
    chk("R8", "far wins", fetch_addr, 32'h00020008);
    cycle(1'b0, 1'b0, 1'b1, 1'b1, "R8");
    chk("R8", "near wins", fetch_addr, 32'h00020077);
    cycle(1'b0, 1'b0, 1'b0, 1'b0, "R9");
    chk("R9", "idle hold", fetch_addr, 32'h00020077);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule